// File: doc/BRIEF.md
# Programmable Square-Wave Tap Selector

This block divides a 32.768 kHz timebase, presented as a one-cycle enable on the system clock, through a 15-stage binary counter. A 4-bit rate code picks one of thirteen counter stages and drives it onto a square-wave pin. The same selected stage also drives a one-cycle periodic tick for an interrupt controller. The most significant stage runs at 1 Hz and drives a one-cycle seconds tick for downstream timekeeping.

Three controls gate the block. An oscillator enable runs the counter; while it is low, every stage is held at zero. A square-wave enable and a power-fail input gate the pin, and the pin stays low while it is disabled or suppressed. The periodic and seconds ticks do not depend on the pin gating.

Top module: `sqw_tap_select`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter clears to zero, and `sqw_out`, `per_tick` and `sec_tick` are low in the following cycle.
- R2: The counter advances by one only on an edge where `osc_en` and `tick_in` are both high. `sec_tick` is high for exactly one cycle when counter bit 14 rises, which is once per 32768 counted ticks.
- R3: Rate code 1 selects counter bit 6 (256 Hz) and code 2 selects bit 7 (128 Hz). Codes 3 to 15 select bit (code − 2), which runs from 8192 Hz down to 2 Hz.
- R4: Rate code 0 selects no stage. `sqw_out` stays low and `per_tick` never fires.
- R5: When `sqw_en` is low at an edge, `sqw_out` is low after that edge.
- R6: When `pwr_fail` is high at an edge, `sqw_out` is low after that edge.
- R7: `sqw_out` is registered. After each edge it equals the selected stage sampled at that edge, ANDed with `sqw_en` and with the inverse of `pwr_fail`.
- R8: `per_tick` is high for one cycle when the selected stage goes from 0 to 1, whatever the values of `sqw_en` and `pwr_fail`.
- R9: An edge with `osc_en` low clears every counter stage to zero. After re-enable, counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | One-cycle 32.768 kHz timebase enable |
| osc_en | input | 1 | Oscillator/divider run enable |
| sqw_en | input | 1 | Square-wave pin enable |
| pwr_fail | input | 1 | Power-fail indication; suppresses the pin |
| rate_sel | input | 4 | Rate code choosing the counter stage |
| sqw_out | output | 1 | Gated square wave |
| per_tick | output | 1 | One-cycle pulse on each rising edge of the selected stage |
| sec_tick | output | 1 | One-cycle 1 Hz pulse |

## Verification
The assertions are checked on every cycle. They cover that both ticks last a single cycle, that the pin is low after any edge where it is disabled, suppressed or given rate code 0, and that no tick fires while the counter is held cleared. Only the bench scenarios can show the tap that each rate code selects, the exact phase of the pin and ticks against the counted timebase, the stall when `tick_in` is sparse, the restart phase after the oscillator enable is toggled, and the single seconds tick over a full 1 Hz interval. For these, the bench compares against a behavioural reference model on every clock.

// File: rtl/sqw_pkg.sv
// Package: shared sizes and the rate-code to counter-stage mapping.
// Assumes codes 1..2 are the slow pair and codes 3..max are a halving ladder.
package sqw_pkg;
    localparam int STAGES    = 15;
    localparam int RSEL_W    = 4;
    localparam int NCODES    = 1 << RSEL_W;
    localparam int SLOW_OFS  = 5;   // code 1 -> bit 6, code 2 -> bit 7
    localparam int FAST_OFS  = 2;   // code 3 -> bit 1

    // Counter bit driven out for a nonzero rate code.
    function automatic int stage_of(input int code);
        if (code < 3) return code + SLOW_OFS;
        return code - FAST_OFS;
    endfunction
endpackage

// File: rtl/sqw_divider.sv
// Module: binary ripple-free divider counter.
// Counts timebase enables while running; a low run enable clears all stages.
module sqw_divider #(
    parameter int STAGES = sqw_pkg::STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    output logic [STAGES-1:0] cnt
);
    // Counter register: clear on reset or stop, increment on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sqw_tap_mux.sv
// Module: picks one counter stage by rate code; code 0 yields constant 0.
// Assumes every mapped stage index lies below STAGES.
module sqw_tap_mux #(
    parameter int STAGES = sqw_pkg::STAGES,
    parameter int RSEL_W = sqw_pkg::RSEL_W
) (
    input  logic [STAGES-1:0] cnt,
    input  logic [RSEL_W-1:0] code,
    output logic              tap
);
    localparam int NC = 1 << RSEL_W;
    logic [NC-1:0] taps;

    assign taps[0] = 1'b0;
    for (genvar c = 1; c < NC; c++) begin : g_tap
        assign taps[c] = cnt[sqw_pkg::stage_of(c)];
    end

    // Route the chosen stage.
    always_comb tap = taps[code];
endmodule

// File: rtl/sqw_out_stage.sv
// Module: registers the gated pin and forms rising-edge ticks.
// Assumes tap and msb change only after clock edges (driven by registers).
module sqw_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic tap,
    input  logic msb,
    input  logic pin_en,
    input  logic pfail,
    output logic pin,
    output logic tap_rise,
    output logic msb_rise
);
    logic tap_d, msb_d;

    // Pin register and edge-history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin   <= 1'b0;
            tap_d <= 1'b0;
            msb_d <= 1'b0;
        end else begin
            pin   <= tap & pin_en & ~pfail;
            tap_d <= tap;
            msb_d <= msb;
        end
    end

    // Edge detectors for the periodic and seconds ticks.
    always_comb begin
        tap_rise = tap & ~tap_d;
        msb_rise = msb & ~msb_d;
    end
endmodule

// File: rtl/sqw_tap_select.sv
// Module: top of the square-wave tap selector.
// Assumes tick_in is a one-cycle enable at 32.768 kHz synchronous to clk.
module sqw_tap_select #(
    parameter int STAGES = sqw_pkg::STAGES,
    parameter int RSEL_W = sqw_pkg::RSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              osc_en,
    input  logic              sqw_en,
    input  logic              pwr_fail,
    input  logic [RSEL_W-1:0] rate_sel,
    output logic              sqw_out,
    output logic              per_tick,
    output logic              sec_tick
);
    logic [STAGES-1:0] cnt;
    logic              tap;

    sqw_divider #(.STAGES(STAGES)) u_div (
        .clk(clk), .rst_n(rst_n), .run(osc_en), .tick(tick_in), .cnt(cnt)
    );

    sqw_tap_mux #(.STAGES(STAGES), .RSEL_W(RSEL_W)) u_mux (
        .cnt(cnt), .code(rate_sel), .tap(tap)
    );

    sqw_out_stage u_out (
        .clk(clk), .rst_n(rst_n), .tap(tap), .msb(cnt[STAGES-1]),
        .pin_en(sqw_en), .pfail(pwr_fail), .pin(sqw_out),
        .tap_rise(per_tick), .msb_rise(sec_tick)
    );
endmodule

// File: rtl/sqw_tap_select_chk.sv
// Checker: port-level properties of the square-wave tap selector.
module sqw_tap_select_chk #(
    parameter int RSEL_W = sqw_pkg::RSEL_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              osc_en,
    input logic              sqw_en,
    input logic              pwr_fail,
    input logic [RSEL_W-1:0] rate_sel,
    input logic              sqw_out,
    input logic              per_tick,
    input logic              sec_tick
);
    p_per_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        per_tick |=> !per_tick);
    p_sec_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);
    p_disabled_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sqw_en |=> !sqw_out);
    p_pfail_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> !sqw_out);
    p_code0_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0) |=> !sqw_out);
    p_code0_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0) |-> !per_tick);
    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> (!sec_tick && !per_tick));
endmodule

bind sqw_tap_select sqw_tap_select_chk #(.RSEL_W(RSEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .sqw_en(sqw_en),
    .pwr_fail(pwr_fail), .rate_sel(rate_sel), .sqw_out(sqw_out),
    .per_tick(per_tick), .sec_tick(sec_tick)
);

// File: tb/sqw_tap_select_test.sv
module sqw_tap_select_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0, tick_in = 1'b0, osc_en = 1'b0, sqw_en = 1'b0, pwr_fail = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic sqw_out, per_tick, sec_tick;

    int checks = 0, fails = 0;
    string cur_req = "R1";
    int tick_every = 1;
    int phase = 0;
    int sec_count = 0;

    // Reference state
    int m_cnt = 0;
    bit m_tapd = 0, m_msbd = 0, m_sqw = 0;

    always #2 clk = ~clk;

    sqw_tap_select uut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .osc_en(osc_en),
        .sqw_en(sqw_en), .pwr_fail(pwr_fail), .rate_sel(rate_sel),
        .sqw_out(sqw_out), .per_tick(per_tick), .sec_tick(sec_tick)
    );

    function automatic bit ref_tap(int cnt, int code);
        int b;
        if (code == 0) return 0;
        b = (code < 3) ? code + 5 : code - 2;   // R3 mapping
        return ((cnt >> b) & 1) != 0;
    endfunction

    // Reference model update on each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_tapd = 0; m_msbd = 0; m_sqw = 0;
        end else begin
            bit t;
            t = ref_tap(m_cnt, rate_sel);
            m_sqw  = t && sqw_en && !pwr_fail;
            m_tapd = t;
            m_msbd = ((m_cnt >> 14) & 1) != 0;
            if (!osc_en) m_cnt = 0;
            else if (tick_in) m_cnt = (m_cnt + 1) % 32768;
        end
    end

    task automatic check(string req, string what, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Compare against the model every cycle, away from the edge.
    always @(negedge clk) begin
        bit ep, es;
        ep = ref_tap(m_cnt, rate_sel) && !m_tapd;
        es = (((m_cnt >> 14) & 1) != 0) && !m_msbd;
        check(cur_req, "sqw_out", sqw_out, m_sqw);
        check(cur_req == "R2" ? "R2" : "R8", "per_tick", per_tick, ep);
        check("R2", "sec_tick", sec_tick, es);
        if (sec_tick) sec_count++;
        // Timebase enable pattern
        phase = (phase + 1) % tick_every;
        tick_in <= (phase == 0);
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        #(4 * 190000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        run(4);
        check("R1", "reset sqw_out", sqw_out, 0);
        check("R1", "reset per_tick", per_tick, 0);
        check("R1", "reset sec_tick", sec_tick, 0);
        rst_n = 1; osc_en = 1; sqw_en = 1;
        // R3 / R7 mapping across codes
        cur_req = "R3";
        rate_sel = 4'd3;  run(64);
        rate_sel = 4'd15; run(1200);
        rate_sel = 4'd1;  run(600);
        rate_sel = 4'd2;  run(600);
        cur_req = "R7";
        rate_sel = 4'd9;  run(1200);
        // R4 code 0
        cur_req = "R4";
        rate_sel = 4'd0; run(300);
        check("R4", "code0 pin", sqw_out, 0);
        // R5 / R6 gating
        cur_req = "R5";
        rate_sel = 4'd5; sqw_en = 0; run(300);
        check("R5", "disabled pin", sqw_out, 0);
        cur_req = "R6";
        sqw_en = 1; pwr_fail = 1; run(300);
        check("R6", "suppressed pin", sqw_out, 0);
        pwr_fail = 0;
        // R2 sparse timebase
        cur_req = "R2";
        tick_every = 3; rate_sel = 4'd4; run(600);
        tick_every = 1;
        // R9 clear and restart
        cur_req = "R9";
        osc_en = 0; run(20);
        check("R9", "stopped per_tick", per_tick, 0);
        osc_en = 1; rate_sel = 4'd3; run(200);
        // R2 one second: counter cleared, run 33000 ticks
        cur_req = "R2";
        osc_en = 0; rate_sel = 4'd15; run(2);
        sec_count = 0;
        osc_en = 1; run(33000);
        check("R2", "one sec_tick per 32768 ticks", sec_count == 1, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule